// File: doc/BRIEF.md
# Measurement Limit Monitor and Alert Flags

This block sits after the measurement datapath of a power monitor. Each time a new shunt, bus, temperature or power result arrives, it compares that result against programmable limits and records any violation in a flag vector. One alert pin summarises the flags. The thresholds, the mode bits and the event inputs come from a register file elsewhere. The current and power arithmetic and the host bus are outside the block.

The comparisons differ by channel. Shunt values and their limits are 16-bit signed. Bus values are compared unsigned against 15-bit thresholds. Temperature is a 12-bit signed value with an over-limit only. For power, only the upper 16 bits of the 24-bit result are compared against the limit.

The mode bits control how the flags and the alert behave:
- Flags can follow the latest sample or hold until a diagnostic read.
- Comparisons can use either every raw sample or only the finished averaged value.
- The alert can be active-low or active-high.
- The alert can optionally include the conversion-ready flag.

Two more status bits are kept: an arithmetic-overflow flag and a trim-memory-health bit.

Top module: `alert_limit_monitor`

## Requirements
- R1: The shunt over flag (`flags_o[0]`) sets when the signed shunt value is strictly greater than the over threshold. The shunt under flag (`flags_o[1]`) sets when the value is strictly less than the under threshold. Both comparisons are 16-bit two's complement.
- R2: Bus values are compared unsigned against 15-bit thresholds, zero-extended. The bus over flag is `flags_o[2]` and uses a strict greater-than. The bus under flag is `flags_o[3]` and uses a strict less-than.
- R3: The temperature over flag (`flags_o[4]`) sets when the 12-bit signed temperature is strictly greater than the 12-bit signed limit.
- R4: The power over flag (`flags_o[5]`) sets when bits 23:8 of the 24-bit power result, taken as unsigned, are strictly greater than the 16-bit limit.
- R5: In transparent mode (`latch_mode_i`=0), each qualifying result strobe re-evaluates that channel's flags. A flag then equals the violation state of the last evaluated sample. A diagnostic read has no effect in this mode. Flags update on the clock edge that samples the strobe.
- R6: In latched mode, a set limit flag stays set until a cycle with `diag_rd_i`=1 clears it. A violation in the same cycle as the read wins, and the flag stays set.
- R7: With `use_avg_i`=1, only `avg_stb_i` qualifies a comparison. With `use_avg_i`=0, only `raw_stb_i` qualifies. A strobe of the other kind has no effect on the flags. Channel index in both strobe vectors: 0 shunt, 1 bus, 2 temperature, 3 power.
- R8: `alert_o` is active when any limit flag is set, or when the conversion-ready flag is set and `cnvr_alert_en_i`=1. The overflow flag does not drive the alert. The alert is active-low with idle 1 when `alert_act_high_i`=0, and active-high with idle 0 when `alert_act_high_i`=1.
- R9: The conversion-ready flag (`flags_o[6]`) sets on `conv_done_i` and clears on `conv_start_i`. In latched mode it also clears on a diagnostic read.
- R10: The overflow flag (`flags_o[7]`) sets on `math_ovf_i`. It clears only on `conv_start_i`; a diagnostic read leaves it set.
- R11: `mem_ok_o` is 1 after reset and drops to 0 on `csum_err_i`. It stays 0 until the next reset.
- R12: After reset, all eight flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_mode_i | input | 1 | 1: flags hold until read; 0: transparent |
| use_avg_i | input | 1 | 1: compare averaged results; 0: compare raw samples |
| cnvr_alert_en_i | input | 1 | Include conversion-ready flag in the alert |
| alert_act_high_i | input | 1 | Alert polarity, 1 = active high |
| raw_stb_i | input | 4 | Raw sample valid, one bit per channel |
| avg_stb_i | input | 4 | Averaged result valid, one bit per channel |
| shunt_val_i | input | 16 | Shunt result, signed |
| bus_val_i | input | 16 | Bus result, non-negative |
| temp_val_i | input | 12 | Temperature result, signed |
| pwr_val_i | input | 24 | Power result, unsigned |
| shunt_ovr_thr_i | input | 16 | Shunt over threshold, signed |
| shunt_und_thr_i | input | 16 | Shunt under threshold, signed |
| bus_ovr_thr_i | input | 15 | Bus over threshold, unsigned |
| bus_und_thr_i | input | 15 | Bus under threshold, unsigned |
| temp_ovr_thr_i | input | 12 | Temperature limit, signed |
| pwr_ovr_thr_i | input | 16 | Power limit, unsigned, compared with result bits 23:8 |
| conv_done_i | input | 1 | Conversion cycle completed |
| conv_start_i | input | 1 | New triggered conversion started |
| math_ovf_i | input | 1 | Current/power arithmetic overflow |
| csum_err_i | input | 1 | Trim memory checksum error |
| diag_rd_i | input | 1 | Diagnostic flag register read |
| flags_o | output | 8 | Flag vector, bit map as in R1 to R10 |
| mem_ok_o | output | 1 | Trim memory healthy |
| alert_o | output | 1 | Alert pin level |

## Verification
The assertions guard the invariants on every clock:
- In latched mode, no limit flag falls except after a read.
- No limit flag rises without a result strobe in the cycle before.
- The conversion-ready flag rises only after a conversion-done pulse.
- The overflow flag falls only after a conversion start.
- The memory-health bit never rises.
- With no active source, the alert sits at its idle level.

The bench scenarios are needed for the rest:
- the exact threshold boundaries, including equality, sign, the bus zero-extension and the power byte discard;
- the set-beats-read priority;
- ignoring strobes of the wrong kind;
- the polarity and conversion-ready routing seen at the alert pin.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int NUM_CH    = 4;
  localparam int CH_SHUNT  = 0;
  localparam int CH_BUS    = 1;
  localparam int CH_TEMP   = 2;
  localparam int CH_PWR    = 3;

  localparam int NUM_LIM   = 6;
  localparam int FL_SH_OV  = 0;
  localparam int FL_SH_UN  = 1;
  localparam int FL_BUS_OV = 2;
  localparam int FL_BUS_UN = 3;
  localparam int FL_TMP_OV = 4;
  localparam int FL_PWR_OV = 5;
  localparam int FL_CNVR   = 6;
  localparam int FL_OVF    = 7;
  localparam int NUM_FLAGS = 8;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
  parameter int W         = 16,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  generate
    if (IS_SIGNED) begin : g_signed
      assign gt_o = $signed(a_i) > $signed(b_i);
    end else begin : g_unsigned
      assign gt_o = a_i > b_i;
    end
  endgenerate
endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter int           N       = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= RST_VAL[i];
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/alert_limit_monitor.sv
module alert_limit_monitor
  import alert_pkg::*;
#(
  parameter int SHUNT_W   = 16,
  parameter int BUS_W     = 16,
  parameter int BUS_THR_W = 15,
  parameter int TEMP_W    = 12,
  parameter int PWR_W     = 24,
  parameter int PWR_LIM_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 latch_mode_i,
  input  logic                 use_avg_i,
  input  logic                 cnvr_alert_en_i,
  input  logic                 alert_act_high_i,
  input  logic [NUM_CH-1:0]    raw_stb_i,
  input  logic [NUM_CH-1:0]    avg_stb_i,
  input  logic [SHUNT_W-1:0]   shunt_val_i,
  input  logic [BUS_W-1:0]     bus_val_i,
  input  logic [TEMP_W-1:0]    temp_val_i,
  input  logic [PWR_W-1:0]     pwr_val_i,
  input  logic [SHUNT_W-1:0]   shunt_ovr_thr_i,
  input  logic [SHUNT_W-1:0]   shunt_und_thr_i,
  input  logic [BUS_THR_W-1:0] bus_ovr_thr_i,
  input  logic [BUS_THR_W-1:0] bus_und_thr_i,
  input  logic [TEMP_W-1:0]    temp_ovr_thr_i,
  input  logic [PWR_LIM_W-1:0] pwr_ovr_thr_i,
  input  logic                 conv_done_i,
  input  logic                 conv_start_i,
  input  logic                 math_ovf_i,
  input  logic                 csum_err_i,
  input  logic                 diag_rd_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 mem_ok_o,
  output logic                 alert_o
);
  localparam int BUS_PAD = BUS_W - BUS_THR_W;
  localparam int PWR_LSB = PWR_W - PWR_LIM_W;

  logic [NUM_CH-1:0]    stb;
  logic [NUM_LIM-1:0]   viol, lim_stb, lim_set, lim_clr;
  logic [BUS_W-1:0]     bus_ovr_ext, bus_und_ext;
  logic [PWR_W-1:0]     pwr_ovr_ext;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr;
  logic [NUM_LIM-1:0]   lim_q;
  logic                 alert_any;

  assign stb         = use_avg_i ? avg_stb_i : raw_stb_i;
  assign bus_ovr_ext = {{BUS_PAD{1'b0}}, bus_ovr_thr_i};
  assign bus_und_ext = {{BUS_PAD{1'b0}}, bus_und_thr_i};
  // value[hi] > lim  <=>  value > {lim, all-ones low part}
  assign pwr_ovr_ext = {pwr_ovr_thr_i, {PWR_LSB{1'b1}}};

  limit_cmp #(.W(SHUNT_W), .IS_SIGNED(1'b1)) u_sh_ov (
    .a_i(shunt_val_i), .b_i(shunt_ovr_thr_i), .gt_o(viol[FL_SH_OV]));
  limit_cmp #(.W(SHUNT_W), .IS_SIGNED(1'b1)) u_sh_un (
    .a_i(shunt_und_thr_i), .b_i(shunt_val_i), .gt_o(viol[FL_SH_UN]));
  limit_cmp #(.W(BUS_W), .IS_SIGNED(1'b0)) u_bus_ov (
    .a_i(bus_val_i), .b_i(bus_ovr_ext), .gt_o(viol[FL_BUS_OV]));
  limit_cmp #(.W(BUS_W), .IS_SIGNED(1'b0)) u_bus_un (
    .a_i(bus_und_ext), .b_i(bus_val_i), .gt_o(viol[FL_BUS_UN]));
  limit_cmp #(.W(TEMP_W), .IS_SIGNED(1'b1)) u_tmp_ov (
    .a_i(temp_val_i), .b_i(temp_ovr_thr_i), .gt_o(viol[FL_TMP_OV]));
  limit_cmp #(.W(PWR_W), .IS_SIGNED(1'b0)) u_pwr_ov (
    .a_i(pwr_val_i), .b_i(pwr_ovr_ext), .gt_o(viol[FL_PWR_OV]));

  always_comb begin
    lim_stb            = '0;
    lim_stb[FL_SH_OV]  = stb[CH_SHUNT];
    lim_stb[FL_SH_UN]  = stb[CH_SHUNT];
    lim_stb[FL_BUS_OV] = stb[CH_BUS];
    lim_stb[FL_BUS_UN] = stb[CH_BUS];
    lim_stb[FL_TMP_OV] = stb[CH_TEMP];
    lim_stb[FL_PWR_OV] = stb[CH_PWR];
  end

  assign lim_set = lim_stb & viol;
  // latched: only a read clears; transparent: a clean sample clears
  assign lim_clr = latch_mode_i ? {NUM_LIM{diag_rd_i}} : (lim_stb & ~viol);

  always_comb begin
    fl_set                 = '0;
    fl_clr                 = '0;
    fl_set[NUM_LIM-1:0]    = lim_set;
    fl_clr[NUM_LIM-1:0]    = lim_clr;
    fl_set[FL_CNVR]        = conv_done_i;
    fl_clr[FL_CNVR]        = conv_start_i | (latch_mode_i & diag_rd_i);
    fl_set[FL_OVF]         = math_ovf_i;
    fl_clr[FL_OVF]         = conv_start_i;
  end

  flag_reg #(.N(NUM_FLAGS), .RST_VAL('0)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(fl_set), .clr_i(fl_clr), .q_o(flags_o));

  flag_reg #(.N(1), .RST_VAL(1'b1)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(1'b0), .clr_i(csum_err_i), .q_o(mem_ok_o));

  assign lim_q     = flags_o[NUM_LIM-1:0];
  assign alert_any = (|lim_q) | (cnvr_alert_en_i & flags_o[FL_CNVR]);
  assign alert_o   = alert_act_high_i ? alert_any : ~alert_any;

  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(latch_mode_i) && (|($past(lim_q) & ~lim_q))) |-> $past(diag_rd_i));

  assert_rise_needs_stb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~$past(lim_q) & lim_q)) |-> (|$past(raw_stb_i | avg_stb_i)));

  assert_cnvr_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[FL_CNVR]) |-> $past(conv_done_i));

  assert_ovf_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_o[FL_OVF]) |-> $past(conv_start_i));

  assert_mem_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(mem_ok_o));

  assert_alert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lim_q == '0) && !flags_o[FL_CNVR]) |-> (alert_o == !alert_act_high_i));
endmodule

// File: tb/tb_alert_limit_monitor.sv
module tb_alert_limit_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        latch_mode = 0, use_avg = 0, cnvr_en = 0, act_high = 0;
  logic [3:0]  raw_stb = '0, avg_stb = '0;
  logic [15:0] shunt_val = '0, bus_val = '0;
  logic [11:0] temp_val = '0;
  logic [23:0] pwr_val = '0;
  logic [15:0] sh_ov = 16'd100, sh_un = 16'hFF9C;  // +100 / -100
  logic [14:0] bus_ov = 15'd1000, bus_un = 15'd200;
  logic [11:0] tmp_ov = 12'h050;
  logic [15:0] pwr_ov = 16'h1234;
  logic        conv_done = 0, conv_start = 0, math_ovf = 0, csum_err = 0, diag_rd = 0;
  logic [7:0]  flags;
  logic        mem_ok, alert;
  int          checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  alert_limit_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .latch_mode_i(latch_mode), .use_avg_i(use_avg),
    .cnvr_alert_en_i(cnvr_en), .alert_act_high_i(act_high),
    .raw_stb_i(raw_stb), .avg_stb_i(avg_stb),
    .shunt_val_i(shunt_val), .bus_val_i(bus_val), .temp_val_i(temp_val), .pwr_val_i(pwr_val),
    .shunt_ovr_thr_i(sh_ov), .shunt_und_thr_i(sh_un), .bus_ovr_thr_i(bus_ov),
    .bus_und_thr_i(bus_un), .temp_ovr_thr_i(tmp_ov), .pwr_ovr_thr_i(pwr_ov),
    .conv_done_i(conv_done), .conv_start_i(conv_start), .math_ovf_i(math_ovf),
    .csum_err_i(csum_err), .diag_rd_i(diag_rd),
    .flags_o(flags), .mem_ok_o(mem_ok), .alert_o(alert));

  // {channel, value, exp_over, exp_under}
  localparam int NV = 19;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 24'h000064, 1'b0, 1'b0}, {2'd0, 24'h000065, 1'b1, 1'b0},
    {2'd0, 24'h00FF9C, 1'b0, 1'b0}, {2'd0, 24'h00FF9B, 1'b0, 1'b1},
    {2'd0, 24'h008000, 1'b0, 1'b1}, {2'd0, 24'h000000, 1'b0, 1'b0},
    {2'd1, 24'h007FFF, 1'b1, 1'b0}, {2'd1, 24'h0003E8, 1'b0, 1'b0},
    {2'd1, 24'h0003E9, 1'b1, 1'b0}, {2'd1, 24'h0000C7, 1'b0, 1'b1},
    {2'd1, 24'h0000C8, 1'b0, 1'b0},
    {2'd2, 24'h000050, 1'b0, 1'b0}, {2'd2, 24'h000051, 1'b1, 1'b0},
    {2'd2, 24'h0007FF, 1'b1, 1'b0}, {2'd2, 24'h000FFF, 1'b0, 1'b0},
    {2'd3, 24'h123400, 1'b0, 1'b0}, {2'd3, 24'h1234FF, 1'b0, 1'b0},
    {2'd3, 24'h123500, 1'b1, 1'b0}, {2'd3, 24'h000001, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive_val(input int ch, input logic [23:0] v);
    case (ch)
      0: shunt_val = v[15:0];
      1: bus_val   = v[15:0];
      2: temp_val  = v[11:0];
      default: pwr_val = v;
    endcase
  endtask

  task automatic sample(input int ch, input logic [23:0] v, input bit avg);
    drive_val(ch, v);
    if (avg) avg_stb[ch] = 1'b1; else raw_stb[ch] = 1'b1;
    tick();
    raw_stb = '0; avg_stb = '0;
  endtask

  task automatic pulse_rd();
    diag_rd = 1'b1; tick(); diag_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R12 / R11 / R8: reset state
    chk("R12 flags after reset", flags, 8'h00);
    chk("R11 mem_ok after reset", mem_ok, 1);
    chk("R8 idle alert active-low", alert, 1);

    // table: transparent mode, raw samples
    for (int i = 0; i < NV; i++) begin
      int ch;
      int ov_idx;
      ch = int'(VEC[i][27:26]);
      ov_idx = (ch == 0) ? 0 : (ch == 1) ? 2 : (ch == 2) ? 4 : 5;
      sample(ch, VEC[i][25:2], 1'b0);
      case (ch)
        0: chk("R1 shunt over", flags[0], VEC[i][1]);
        1: chk("R2 bus over",   flags[2], VEC[i][1]);
        2: chk("R3 temp over",  flags[4], VEC[i][1]);
        default: chk("R4 power over", flags[5], VEC[i][1]);
      endcase
      if (ch == 0) chk("R1 shunt under", flags[1], VEC[i][0]);
      if (ch == 1) chk("R2 bus under",   flags[3], VEC[i][0]);
      chk("R8 alert tracks flags", alert, (flags[5:0] == 0) ? 1 : 0);
      if (ov_idx < 0) chk("unused", 0, 1);
    end
    chk("R5 all clear after clean samples", flags, 8'h00);

    // R5: transparent, read has no effect
    sample(0, 24'd200, 1'b0);
    chk("R5 set", flags[0], 1);
    pulse_rd();
    chk("R5 read ignored in transparent", flags[0], 1);
    sample(0, 24'd0, 1'b0);
    chk("R5 clean sample clears", flags[0], 0);

    // R6: latched mode
    latch_mode = 1'b1;
    sample(0, 24'd200, 1'b0);
    chk("R6 latched set", flags[0], 1);
    chk("R8 alert active", alert, 0);
    sample(0, 24'd0, 1'b0);
    chk("R6 held after clean sample", flags[0], 1);
    pulse_rd();
    chk("R6 read clears", flags[0], 0);
    shunt_val = 16'd200; raw_stb[0] = 1'b1; diag_rd = 1'b1;
    tick();
    raw_stb = '0; diag_rd = 1'b0;
    chk("R6 set wins over read", flags[0], 1);
    pulse_rd();
    chk("R6 cleared", flags[0], 0);
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk("R9 cnvr set latched", flags[6], 1);
    pulse_rd();
    chk("R9 cnvr cleared by read in latched", flags[6], 0);
    latch_mode = 1'b0;

    // R7: sample selection
    use_avg = 1'b1;
    sample(0, 24'd200, 1'b0);
    chk("R7 raw ignored when avg selected", flags[0], 0);
    sample(0, 24'd200, 1'b1);
    chk("R7 avg strobe compares", flags[0], 1);
    sample(0, 24'd0, 1'b0);
    chk("R7 raw clean ignored", flags[0], 1);
    sample(0, 24'd0, 1'b1);
    chk("R7 avg clean clears", flags[0], 0);
    use_avg = 1'b0;
    sample(0, 24'd200, 1'b1);
    chk("R7 avg ignored when raw selected", flags[0], 0);

    // R8: polarity
    act_high = 1'b1; #1;
    chk("R8 active-high idle", alert, 0);
    sample(1, 24'd5000, 1'b0);
    chk("R8 active-high asserted", alert, 1);
    sample(1, 24'd500, 1'b0);
    act_high = 1'b0; #1;
    chk("R8 back to idle high", alert, 1);

    // R9: conversion ready routing (transparent)
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk("R9 cnvr set", flags[6], 1);
    chk("R9 not routed", alert, 1);
    cnvr_en = 1'b1; #1;
    chk("R9 routed to alert", alert, 0);
    pulse_rd();
    chk("R9 read ignored transparent", flags[6], 1);
    conv_start = 1'b1; tick(); conv_start = 1'b0;
    chk("R9 cleared by start", flags[6], 0);
    chk("R9 alert idle", alert, 1);
    cnvr_en = 1'b0;

    // R10: overflow
    math_ovf = 1'b1; tick(); math_ovf = 1'b0;
    chk("R10 ovf set", flags[7], 1);
    chk("R8 ovf not on alert", alert, 1);
    latch_mode = 1'b1;
    pulse_rd();
    chk("R10 read does not clear", flags[7], 1);
    latch_mode = 1'b0;
    conv_start = 1'b1; tick(); conv_start = 1'b0;
    chk("R10 start clears", flags[7], 0);

    // R11: memory status
    csum_err = 1'b1; tick(); csum_err = 1'b0;
    chk("R11 mem_ok drops", mem_ok, 0);
    conv_start = 1'b1; diag_rd = 1'b1; tick(); conv_start = 1'b0; diag_rd = 1'b0;
    tick();
    chk("R11 mem_ok sticky", mem_ok, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule